// File: doc/BRIEF.md
# Two-Thread Shared Multiply-Divide Unit

This unit executes 32x32 multiply, multiply-accumulate and divide operations for two hardware threads. Each thread owns a private 64-bit result pair (HI, LO). The arithmetic hardware is shared. Every operation arrives on one issue port with a thread tag. Its result lands only in the pair that belongs to that tag.

Multiplies and accumulates flow through a fixed-depth pipeline and can be accepted on every clock. Divides run on a separate iterative radix-4 engine that retires two quotient bits per cycle. Before it iterates, the engine skips the leading zero bit-pairs of the dividend magnitude, so a short dividend finishes sooner.

A per-thread read port shows the thread's pair. It signals not-ready while that thread still has work in flight. Per-thread busy and done flags let the surrounding pipeline know when results can be consumed.

Top module: `shared_mdu`

## Requirements
- R1: After reset both result pairs read zero, busy and done are low for both threads, the read port is ready, and a multiply is ready to issue.
- R2: The opcode is decoded bitwise. Bit 2 set means divide. Bit 1 set (with bit 2 clear) means accumulate. Bit 0 set means unsigned operands, clear means signed. A plain multiply accepted at clock edge e writes the 64-bit product to {HI,LO} at edge e+3.
- R3: A multiply-accumulate accepted at edge e writes {HI,LO} plus the product, modulo 2^64, at edge e+4. The starting value includes every earlier write to that thread, including an accumulate issued one cycle before.
- R4: A multiply or accumulate is ready on every cycle unless a divide for the same thread is in flight.
- R5: A divide accepted at edge e completes at edge e+n+2. Here n is the number of significant bit-pairs in the dividend magnitude (half the bit index of its highest set bit, plus one), with a minimum of 1. The latency therefore spans 3 to 18 cycles.
- R6: A divide writes the quotient to LO and the remainder to HI. A signed divide truncates toward zero, and its remainder carries the dividend's sign.
- R7: A divide is ready only when no divide is in flight and the issuing thread has nothing in flight. While a divide runs, the other thread's multiplies keep issuing.
- R8: Each result is written only to the pair of the thread tag issued with it. The other thread's pair is left unchanged.
- R9: busy for a thread is high from the acceptance of its first outstanding operation until the edge that writes its last one. The read port reports not-ready exactly while the selected thread is busy.
- R10: done for a thread is high for one cycle after each edge that writes that thread's pair, and at no other time.
- R11: A divide by zero completes with the normal latency for its dividend and leaves the unit able to accept work.
- R12: When an accumulate is followed one cycle later by a plain multiply for the same thread, both complete at the same edge and the multiply's product is what remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request present |
| iss_op | input | 3 | Operation code (bit 2 divide, bit 1 accumulate, bit 0 unsigned) |
| iss_tid | input | TW | Thread tag of the issued operation |
| iss_a | input | DW | First operand (dividend for divides) |
| iss_b | input | DW | Second operand (divisor for divides) |
| iss_ready | output | 1 | Issue can be accepted this cycle |
| rd_tid | input | TW | Thread whose pair is shown on the read port |
| rd_hi | output | DW | HI of the selected thread |
| rd_lo | output | DW | LO of the selected thread |
| rd_ready | output | 1 | Selected thread has no operation in flight |
| busy | output | THREADS | Per-thread in-flight indication |
| done | output | THREADS | Per-thread completion pulse |

## Verification
Several completions can land on the same clock edge. An accumulate can retire at the same edge as a multiply of the same thread that was issued one cycle later. An accumulate can also need the value that the accumulate just ahead of it is writing on that edge. A divide can finish in the same cycle as a multiply of the other thread. The bench provokes these cases by issuing back-to-back accumulate/multiply pairs and by streaming multiplies for the other thread while a divide runs. A behavioural queue of pending writes, ordered by completion cycle and then by issue order, predicts the surviving value for each thread. That prediction is compared with the read port, busy and done on every cycle.

// File: rtl/mdu_pkg.sv
`timescale 1ns/1ps
package mdu_pkg;

   typedef enum logic [2:0] {
      MDU_MUL  = 3'b000,
      MDU_MULU = 3'b001,
      MDU_MAC  = 3'b010,
      MDU_MACU = 3'b011,
      MDU_DIV  = 3'b100,
      MDU_DIVU = 3'b101
   } mdu_op_e;

   typedef struct packed {
      logic div;
      logic acc;
      logic sgn;
   } mdu_ctl_t;

   function automatic mdu_ctl_t mdu_decode(logic [2:0] op);
      mdu_ctl_t c;
      c.div = op[2];
      c.acc = op[1] & ~op[2];
      c.sgn = ~op[0];
      return c;
   endfunction

endpackage

// File: rtl/mdu_mul_pipe.sv
`timescale 1ns/1ps
module mdu_mul_pipe #(
   parameter int DW      = 32,
   parameter int THREADS = 2,
   localparam int TW     = (THREADS > 1) ? $clog2(THREADS) : 1,
   localparam int PW     = 2 * DW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_v,
   input  logic [TW-1:0]   in_tid,
   input  logic            in_acc,
   input  logic            in_sgn,
   input  logic [DW-1:0]   in_a,
   input  logic [DW-1:0]   in_b,
   output logic [TW-1:0]   acc_tid,
   input  logic [PW-1:0]   acc_val,
   output logic            mw_v,
   output logic [TW-1:0]   mw_tid,
   output logic [PW-1:0]   mw_val,
   output logic            aw_v,
   output logic [TW-1:0]   aw_tid,
   output logic [PW-1:0]   aw_val,
   output logic [THREADS-1:0] occ
);

   logic            s1_v, s2_v, s3_v, s4_v;
   logic [TW-1:0]   s1_tid, s2_tid, s3_tid, s4_tid;
   logic            s1_acc, s2_acc, s3_acc;
   logic [PW-1:0]   s1_a, s1_b, s2_prod, s3_prod, s4_sum;
   logic [PW-1:0]   acc_src;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v <= 1'b0;
         s2_v <= 1'b0;
         s3_v <= 1'b0;
         s4_v <= 1'b0;
      end else begin
         s1_v <= in_v;
         s2_v <= s1_v;
         s3_v <= s2_v;
         s4_v <= s3_v & s3_acc;
      end
   end

   always_ff @(posedge clk) begin
      s1_tid  <= in_tid;
      s1_acc  <= in_acc;
      s1_a    <= in_sgn ? {{DW{in_a[DW-1]}}, in_a} : {{DW{1'b0}}, in_a};
      s1_b    <= in_sgn ? {{DW{in_b[DW-1]}}, in_b} : {{DW{1'b0}}, in_b};
      s2_tid  <= s1_tid;
      s2_acc  <= s1_acc;
      s2_prod <= s1_a * s1_b;
      s3_tid  <= s2_tid;
      s3_acc  <= s2_acc;
      s3_prod <= s2_prod;
      s4_tid  <= s3_tid;
      s4_sum  <= s3_prod + acc_src;
   end

   // Accumulate source: forward the sum that is retiring on this very edge.
   assign acc_tid = s3_tid;
   assign acc_src = (s4_v && (s4_tid == s3_tid)) ? s4_sum : acc_val;

   assign mw_v   = s3_v & ~s3_acc;
   assign mw_tid = s3_tid;
   assign mw_val = s3_prod;
   assign aw_v   = s4_v;
   assign aw_tid = s4_tid;
   assign aw_val = s4_sum;

   for (genvar t = 0; t < THREADS; t++) begin : g_occ
      assign occ[t] = (s1_v && s1_tid == TW'(t)) || (s2_v && s2_tid == TW'(t)) ||
                      (s3_v && s3_tid == TW'(t)) || (s4_v && s4_tid == TW'(t));
   end

   // R4: the pipeline never stalls, so every third-stage entry came from stage one two edges back
   a_r4_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      s3_v |-> $past(s1_v, 2));

endmodule

// File: rtl/mdu_divider.sv
`timescale 1ns/1ps
module mdu_divider #(
   parameter int DW      = 32,
   parameter int THREADS = 2,
   localparam int TW     = (THREADS > 1) ? $clog2(THREADS) : 1,
   localparam int NP     = DW / 2,
   localparam int CW     = $clog2(NP + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [TW-1:0]   start_tid,
   input  logic            start_sgn,
   input  logic [DW-1:0]   start_a,
   input  logic [DW-1:0]   start_b,
   output logic            busy,
   output logic [TW-1:0]   cur_tid,
   output logic            wb_v,
   output logic [DW-1:0]   wb_hi,
   output logic [DW-1:0]   wb_lo
);

   typedef enum logic [1:0] {D_IDLE, D_RUN, D_FIX, D_WB} dstate_e;

   dstate_e         st;
   logic [DW-1:0]   dvd, rem, quo, dsr;
   logic [CW-1:0]   cnt;
   logic            neg_q, neg_r;
   logic [DW-1:0]   abs_a, abs_b;
   logic [CW-1:0]   n_pairs;
   logic [DW:0]     st1, st2;

   function automatic logic [CW-1:0] sig_pairs(logic [DW-1:0] v);
      int hi_bit;
      hi_bit = -1;
      for (int i = 0; i < DW; i++) begin
         if (v[i]) hi_bit = i;
      end
      return (hi_bit < 0) ? CW'(1) : CW'(hi_bit / 2 + 1);
   endfunction

   // one restoring step: returns {quotient bit, new partial remainder}
   function automatic logic [DW:0] rstep(logic [DW-1:0] r, logic nb, logic [DW-1:0] d);
      logic [DW:0] tmp;
      logic        q;
      tmp = {r, nb};
      q   = (tmp >= {1'b0, d});
      if (q) tmp = tmp - {1'b0, d};
      return {q, tmp[DW-1:0]};
   endfunction

   assign abs_a   = (start_sgn && start_a[DW-1]) ? (~start_a + 1'b1) : start_a;
   assign abs_b   = (start_sgn && start_b[DW-1]) ? (~start_b + 1'b1) : start_b;
   assign n_pairs = sig_pairs(abs_a);

   always_comb begin
      st1 = rstep(rem, dvd[DW-1], dsr);
      st2 = rstep(st1[DW-1:0], dvd[DW-2], dsr);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= D_IDLE;
      end else begin
         case (st)
            D_IDLE: if (start) st <= D_RUN;
            D_RUN:  if (cnt == CW'(1)) st <= D_FIX;
            D_FIX:  st <= D_WB;
            default: st <= D_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (st == D_IDLE && start) begin
         dvd     <= abs_a << (2 * (NP - int'(n_pairs)));
         rem     <= '0;
         quo     <= '0;
         dsr     <= abs_b;
         cnt     <= n_pairs;
         neg_q   <= start_sgn & (start_a[DW-1] ^ start_b[DW-1]);
         neg_r   <= start_sgn & start_a[DW-1];
         cur_tid <= start_tid;
      end else if (st == D_RUN) begin
         rem <= st2[DW-1:0];
         quo <= {quo[DW-3:0], st1[DW], st2[DW]};
         dvd <= dvd << 2;
         cnt <= cnt - CW'(1);
      end else if (st == D_FIX) begin
         wb_lo <= neg_q ? (~quo + 1'b1) : quo;
         wb_hi <= neg_r ? (~rem + 1'b1) : rem;
      end
   end

   assign busy = (st != D_IDLE);
   assign wb_v = (st == D_WB);

   // checker-side run-length counter for the latency bound
   logic [CW+1:0] run_len;
   always_ff @(posedge clk) begin
      if (!rst_n || (st == D_IDLE)) run_len <= '0;
      else                          run_len <= run_len + 1'b1;
   end

   // R5: at most NP iterations plus the fix-up and write-back cycles
   a_r5_latency_cap: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (int'(run_len) <= NP + 1));

   // R7: a start is only seen by an idle engine
   a_r7_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

endmodule

// File: rtl/mdu_hilo_bank.sv
`timescale 1ns/1ps
module mdu_hilo_bank #(
   parameter int DW      = 32,
   parameter int THREADS = 2,
   localparam int TW     = (THREADS > 1) ? $clog2(THREADS) : 1,
   localparam int PW     = 2 * DW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mw_v,
   input  logic [TW-1:0]   mw_tid,
   input  logic [PW-1:0]   mw_val,
   input  logic            aw_v,
   input  logic [TW-1:0]   aw_tid,
   input  logic [PW-1:0]   aw_val,
   input  logic            dw_v,
   input  logic [TW-1:0]   dw_tid,
   input  logic [PW-1:0]   dw_val,
   input  logic [TW-1:0]   acc_tid,
   output logic [PW-1:0]   acc_val,
   input  logic [TW-1:0]   rd_tid,
   output logic [PW-1:0]   rd_val,
   output logic [THREADS-1:0] done
);

   logic [PW-1:0] pair [THREADS];

   for (genvar t = 0; t < THREADS; t++) begin : g_thr
      logic          wm, wa, wd, dq;
      logic [PW-1:0] q;

      assign wm = mw_v && (mw_tid == TW'(t));
      assign wa = aw_v && (aw_tid == TW'(t));
      assign wd = dw_v && (dw_tid == TW'(t));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q  <= '0;
            dq <= 1'b0;
         end else begin
            dq <= wm | wa | wd;
            // later-issued multiply beats an accumulate retiring on the same edge
            if (wd)      q <= dw_val;
            else if (wm) q <= mw_val;
            else if (wa) q <= aw_val;
         end
      end

      assign pair[t] = q;
      assign done[t] = dq;

      // R8: a divide result never collides with a multiply-path write of the same thread
      a_r8_div_alone: assert property (@(posedge clk) disable iff (!rst_n)
         !(wd && (wm || wa)));
   end

   assign acc_val = pair[acc_tid];
   assign rd_val  = pair[rd_tid];

endmodule

// File: rtl/shared_mdu.sv
`timescale 1ns/1ps
module shared_mdu
   import mdu_pkg::*;
#(
   parameter int DW      = 32,
   parameter int THREADS = 2,
   localparam int TW     = (THREADS > 1) ? $clog2(THREADS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               iss_valid,
   input  logic [2:0]         iss_op,
   input  logic [TW-1:0]      iss_tid,
   input  logic [DW-1:0]      iss_a,
   input  logic [DW-1:0]      iss_b,
   output logic               iss_ready,
   input  logic [TW-1:0]      rd_tid,
   output logic [DW-1:0]      rd_hi,
   output logic [DW-1:0]      rd_lo,
   output logic               rd_ready,
   output logic [THREADS-1:0] busy,
   output logic [THREADS-1:0] done
);

   localparam int PW = 2 * DW;

   if (DW < 4 || (DW % 2) != 0) begin : g_bad_dw
      $error("shared_mdu: DW must be even and at least 4");
   end
   if (THREADS < 2) begin : g_bad_thr
      $error("shared_mdu: THREADS must be at least 2");
   end

   mdu_ctl_t             ctl;
   logic                 fire, mul_fire, div_fire;
   logic                 div_busy, div_wb;
   logic [TW-1:0]        div_tid;
   logic [DW-1:0]        div_hi, div_lo;
   logic [THREADS-1:0]   occ;
   logic [TW-1:0]        acc_tid;
   logic [PW-1:0]        acc_val, rd_val;
   logic                 mw_v, aw_v;
   logic [TW-1:0]        mw_tid, aw_tid;
   logic [PW-1:0]        mw_val, aw_val;

   assign ctl = mdu_decode(iss_op);

   always_comb begin
      if (ctl.div) iss_ready = !div_busy && !occ[iss_tid];
      else         iss_ready = !(div_busy && (div_tid == iss_tid));
   end

   assign fire     = iss_valid && iss_ready;
   assign mul_fire = fire && !ctl.div;
   assign div_fire = fire && ctl.div;

   mdu_mul_pipe #(.DW(DW), .THREADS(THREADS)) u_mul (
      .clk(clk), .rst_n(rst_n),
      .in_v(mul_fire), .in_tid(iss_tid), .in_acc(ctl.acc), .in_sgn(ctl.sgn),
      .in_a(iss_a), .in_b(iss_b),
      .acc_tid(acc_tid), .acc_val(acc_val),
      .mw_v(mw_v), .mw_tid(mw_tid), .mw_val(mw_val),
      .aw_v(aw_v), .aw_tid(aw_tid), .aw_val(aw_val),
      .occ(occ)
   );

   mdu_divider #(.DW(DW), .THREADS(THREADS)) u_div (
      .clk(clk), .rst_n(rst_n),
      .start(div_fire), .start_tid(iss_tid), .start_sgn(ctl.sgn),
      .start_a(iss_a), .start_b(iss_b),
      .busy(div_busy), .cur_tid(div_tid),
      .wb_v(div_wb), .wb_hi(div_hi), .wb_lo(div_lo)
   );

   mdu_hilo_bank #(.DW(DW), .THREADS(THREADS)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .mw_v(mw_v), .mw_tid(mw_tid), .mw_val(mw_val),
      .aw_v(aw_v), .aw_tid(aw_tid), .aw_val(aw_val),
      .dw_v(div_wb), .dw_tid(div_tid), .dw_val({div_hi, div_lo}),
      .acc_tid(acc_tid), .acc_val(acc_val),
      .rd_tid(rd_tid), .rd_val(rd_val),
      .done(done)
   );

   for (genvar t = 0; t < THREADS; t++) begin : g_busy
      assign busy[t] = occ[t] || (div_busy && (div_tid == TW'(t)));

      // R10: a completion pulse only follows a cycle in which the thread was busy
      a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
         done[t] |-> $past(busy[t]));
   end

   assign rd_ready = !busy[rd_tid];
   assign {rd_hi, rd_lo} = rd_val;

   // R7: an accepted divide takes the engine for the issuing thread
   a_r7_div_claims: assert property (@(posedge clk) disable iff (!rst_n)
      div_fire |=> (div_busy && (div_tid == $past(iss_tid))));

endmodule

// File: tb/shared_mdu_test.sv
`timescale 1ns/1ps
module shared_mdu_test;
   import mdu_pkg::*;

   localparam int DW = 32;
   localparam int NT = 2;
   localparam int TW = 1;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              iss_valid;
   logic [2:0]        iss_op;
   logic [TW-1:0]     iss_tid;
   logic [DW-1:0]     iss_a, iss_b;
   logic              iss_ready;
   logic [TW-1:0]     rd_tid;
   logic [DW-1:0]     rd_hi, rd_lo;
   logic              rd_ready;
   logic [NT-1:0]     busy, done;

   always #4 clk = ~clk;

   shared_mdu #(.DW(DW), .THREADS(NT)) uut (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_op(iss_op), .iss_tid(iss_tid),
      .iss_a(iss_a), .iss_b(iss_b), .iss_ready(iss_ready),
      .rd_tid(rd_tid), .rd_hi(rd_hi), .rd_lo(rd_lo), .rd_ready(rd_ready),
      .busy(busy), .done(done)
   );

   typedef struct {
      int              due;
      int              tid;
      int              kind;   // 0 multiply, 1 accumulate, 2 divide
      longint unsigned val;
      bit              known;
      string           dtag;
      string           vtag;
   } pend_t;

   pend_t           pq[$];
   longint unsigned m_hl [NT];
   bit              m_known [NT];
   string           m_vtag [NT];
   int              cyc = 0;
   int              errs = 0;
   int              checks = 0;

   task automatic check(bit ok, string tag, longint unsigned act, longint unsigned exp, string what);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", tag, what, cyc, act, exp);
      end
   endtask

   function automatic int div_latency(longint unsigned mag);
      int hb = -1;
      for (int i = 0; i < DW; i++) if (mag[i]) hb = i;
      return ((hb < 0) ? 1 : hb / 2 + 1) + 2;
   endfunction

   task automatic step(bit v, logic [2:0] op, int tid, logic [DW-1:0] a, logic [DW-1:0] b, string vtag_in = "");
      bit    pdiv_t, any_div, any_t, er, acc;
      bit    edone [NT];
      string ddt [NT];
      bit    eb [NT];
      pend_t keep[$];
      int    r;
      iss_valid = v;
      iss_op    = op;
      iss_tid   = TW'(tid);
      iss_a     = a;
      iss_b     = b;
      r         = cyc % 2;
      rd_tid    = TW'(r);
      #1;
      pdiv_t = 0; any_div = 0; any_t = 0;
      foreach (pq[i]) begin
         if (pq[i].kind == 2) any_div = 1;
         if (pq[i].kind == 2 && pq[i].tid == tid) pdiv_t = 1;
         if (pq[i].tid == tid) any_t = 1;
      end
      er = op[2] ? (!any_div && !any_t) : !pdiv_t;
      check(iss_ready == er, (op[2] || pdiv_t) ? "R7" : "R4", 64'(iss_ready), 64'(er), "issue ready");
      acc = v && er;
      @(posedge clk);
      cyc++;
      if (acc) begin
         pend_t e;
         bit sg;
         sg = !op[2:0][0];
         e.tid = tid;
         e.known = 1;
         if (op[2]) begin
            longint sa, sb, q, rm;
            longint unsigned mag;
            sa = sg ? longint'($signed(a)) : longint'(a);
            sb = sg ? longint'($signed(b)) : longint'(b);
            mag = (sa < 0) ? longint'(-sa) : sa;
            e.kind = 2;
            e.due  = cyc + div_latency(mag);
            e.dtag = "R5";
            e.vtag = (vtag_in != "") ? vtag_in : "R6";
            if (b == 0) begin
               e.known = 0;
               e.val   = 0;
               e.dtag  = "R11";
            end else begin
               q  = sa / sb;
               rm = sa % sb;
               e.val = {rm[31:0], q[31:0]};
            end
         end else begin
            longint sa, sb;
            sa = sg ? longint'($signed(a)) : longint'(a);
            sb = sg ? longint'($signed(b)) : longint'(b);
            e.val  = longint'(sa * sb);
            e.kind = op[1] ? 1 : 0;
            e.due  = cyc + (op[1] ? 4 : 3);
            e.dtag = op[1] ? "R3" : "R2";
            e.vtag = (vtag_in != "") ? vtag_in : e.dtag;
         end
         pq.push_back(e);
      end
      for (int t = 0; t < NT; t++) begin edone[t] = 0; ddt[t] = "R10"; end
      foreach (pq[i]) begin
         if (pq[i].due == cyc) begin
            int t;
            t = pq[i].tid;
            if (pq[i].kind == 1) m_hl[t] = m_hl[t] + pq[i].val;
            else                 m_hl[t] = pq[i].val;
            if (pq[i].kind == 0) m_known[t] = 1;
            if (pq[i].kind == 2) m_known[t] = pq[i].known;
            m_vtag[t] = pq[i].vtag;
            edone[t] = 1;
            ddt[t] = pq[i].dtag;
         end else begin
            keep.push_back(pq[i]);
         end
      end
      pq = keep;
      for (int t = 0; t < NT; t++) eb[t] = 0;
      foreach (pq[i]) eb[pq[i].tid] = 1;
      @(negedge clk);
      for (int t = 0; t < NT; t++) begin
         check(done[t] == edone[t], ddt[t], 64'(done[t]), 64'(edone[t]), $sformatf("done thread %0d", t));
         check(busy[t] == eb[t], "R9", 64'(busy[t]), 64'(eb[t]), $sformatf("busy thread %0d", t));
      end
      check(rd_ready == !eb[r], "R9", 64'(rd_ready), 64'(!eb[r]), "read ready");
      if (!eb[r] && m_known[r])
         check({rd_hi, rd_lo} == m_hl[r], {m_vtag[r], "/R8"}, {rd_hi, rd_lo}, m_hl[r],
               $sformatf("pair thread %0d", r));
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 3'b000, 0, '0, '0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL R5 watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      for (int t = 0; t < NT; t++) begin m_hl[t] = 0; m_known[t] = 1; m_vtag[t] = "R1"; end
      rst_n = 0; iss_valid = 0; iss_op = 0; iss_tid = 0; iss_a = 0; iss_b = 0; rd_tid = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      // R1 reset state
      check(busy == '0, "R1", 64'(busy), 0, "busy after reset");
      check(done == '0, "R1", 64'(done), 0, "done after reset");
      check(rd_ready == 1'b1, "R1", 64'(rd_ready), 1, "read ready after reset");
      check({rd_hi, rd_lo} == 64'd0, "R1", {rd_hi, rd_lo}, 0, "pair 0 after reset");
      rd_tid = 1; #1;
      check({rd_hi, rd_lo} == 64'd0, "R1", {rd_hi, rd_lo}, 0, "pair 1 after reset");
      check(iss_ready == 1'b1, "R1", 64'(iss_ready), 1, "multiply ready after reset");

      // R2 single multiplies, signed and unsigned
      step(1, MDU_MUL, 0, 32'(-7), 32'd3);
      idle(4);
      step(1, MDU_MULU, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      idle(4);
      step(1, MDU_MUL, 1, 32'h8000_0000, 32'h8000_0000);
      idle(4);

      // R4 back-to-back issue, threads alternating
      for (int i = 0; i < 8; i++)
         step(1, (i % 2) ? MDU_MULU : MDU_MUL, i % 2, 32'(1000 + i * 77), 32'(-(i + 3)));
      idle(4);

      // R3 accumulate chains, including one-cycle dependence
      step(1, MDU_MUL, 0, 32'd5, 32'd6);
      step(1, MDU_MAC, 0, 32'd2, 32'd3);
      step(1, MDU_MAC, 0, 32'(-4), 32'd5);
      step(1, MDU_MACU, 1, 32'd7, 32'hFFFF_0000);
      step(1, MDU_MAC, 0, 32'd9, 32'd9);
      step(1, MDU_MACU, 1, 32'hFFFF_FFFF, 32'd2);
      idle(6);

      // R12 accumulate then multiply on the same thread
      step(1, MDU_MAC, 0, 32'd3, 32'd3);
      step(1, MDU_MUL, 0, 32'd11, 32'd13, "R12");
      idle(6);

      // R6/R7 divide with other-thread multiplies streaming, blocked attempts
      step(1, MDU_DIV, 0, 32'(-100), 32'd7);
      step(1, MDU_MUL, 1, 32'd21, 32'd2);
      step(1, MDU_DIV, 1, 32'd50, 32'd5);
      step(1, MDU_MUL, 0, 32'd4, 32'd4);
      step(1, MDU_MULU, 1, 32'd99, 32'd3);
      idle(20);
      step(1, MDU_MUL, 0, 32'd8, 32'd8);
      step(1, MDU_DIV, 0, 32'd8, 32'd2);
      idle(6);

      // R5 latency by dividend size
      step(1, MDU_DIVU, 0, 32'd3, 32'd2);
      idle(5);
      step(1, MDU_DIVU, 1, 32'd0, 32'd5);
      idle(5);
      step(1, MDU_DIVU, 0, 32'hFFFF_FFFF, 32'd3);
      idle(20);
      step(1, MDU_DIV, 1, 32'h0001_0000, 32'(-3));
      idle(14);
      step(1, MDU_DIV, 0, 32'h8000_0000, 32'hFFFF_FFFF);
      idle(20);
      step(1, MDU_DIV, 1, 32'(-45), 32'(-7));
      idle(10);

      // R11 divide by zero completes, unit stays usable
      step(1, MDU_DIVU, 1, 32'd1234, 32'd0);
      idle(16);
      step(1, MDU_MUL, 1, 32'd2, 32'd2);
      idle(4);

      // mixed traffic
      for (int i = 0; i < 400; i++) begin
         logic [2:0]    op;
         logic [DW-1:0] a, b;
         int sel;
         sel = $urandom % 10;
         op  = (sel < 3) ? MDU_MUL : (sel < 5) ? MDU_MULU : (sel < 7) ? MDU_MAC :
               (sel < 8) ? MDU_MACU : (sel < 9) ? MDU_DIV : MDU_DIVU;
         a = ($urandom % 3 == 0) ? DW'($urandom % 300) : DW'($urandom);
         b = ($urandom % 2 == 0) ? DW'($urandom % 50) : DW'($urandom);
         if (op[2] && b == 0) b = 32'd9;
         step(($urandom % 4) != 0, op, $urandom % 2, a, b);
      end
      idle(25);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule